// File: doc/BRIEF.md
# SMBus Alert Notification Responder

This block is the slave-side alert logic of a management sideband SMBus device. When a message is waiting for the management controller, it pulls the shared, open-drain, active-low alert line. A message is waiting after a network packet addressed to the controller, after a status request, or after a status change while change notification is enabled. The controller can then service the alert in one of two ways.

- It can run an Alert Response Address cycle. The block answers with its own address and releases the alert when that cycle completes.
- It can write a command byte straight to the block's slave address. The alert is released as soon as that command byte has been received.

A programmable timeout also releases an alert that nobody services. The block watches the bus through two-flop synchronisers and drives SDA only by a pull-low enable.

The bus state machine has these states:

- **ST_IDLE**: the bus is free.
- **ST_ADDR**: an address byte is being received.
- **ST_ACK_ARA**: an alert response address is being acknowledged.
- **ST_TX**: the own-address byte is being sent.
- **ST_TX_ACK**: the master's acknowledge bit is sampled.
- **ST_ACK_WR** and **ST_ACK_RD**: a write or read to the own address is being acknowledged.
- **ST_RX_CMD**: the command byte is being received.
- **ST_ACK_CMD**: the command byte is being acknowledged.
- **ST_WAIT_STOP**: the block waits for the end of the transfer.

Transitions:

- A START from any state goes to ST_ADDR.
- A STOP from any state goes to ST_IDLE.
- After eight address bits, ST_ADDR goes to one of ST_ACK_ARA, ST_ACK_WR, ST_ACK_RD or ST_WAIT_STOP.
- ST_ACK_ARA goes to ST_TX.
- ST_TX goes to ST_TX_ACK after eight bits, or to ST_WAIT_STOP when arbitration is lost.
- ST_TX_ACK goes to ST_WAIT_STOP.
- ST_ACK_WR goes to ST_RX_CMD, then ST_ACK_CMD, then ST_WAIT_STOP.
- ST_ACK_RD goes to ST_WAIT_STOP.

Top module: `smb_alert_responder`

## Requirements
- R1: While reset is held and right after it, `sda_pull` and `alert_pull` are both 0.
- R2: When `alert_mode`=1, a one-cycle pulse on `ev_lan_pkt` or `ev_status_req` raises `alert_pull` on the next clock. So does a pulse on `ev_status_chg` while `chg_notify_en`=1. A pulse on `ev_status_chg` with `chg_notify_en`=0 has no effect. With `alert_mode`=0, no event raises the alert.
- R3: While `alert_pull`=1, an address byte of 0x19 (7-bit address 0001100b followed by read bit 1) is acknowledged. The block then sends, MSB first, the byte {own_addr, 1'b1}. SDA pull-low only begins while the synchronised SCL is low.
- R4: After a won alert response cycle, the STOP (or a repeated START) that ends it drops `alert_pull`.
- R5: While `alert_pull`=0, the alert response address 0x19 is not acknowledged and SDA is not pulled.
- R6: A write (R/W bit 0) to `own_addr` is acknowledged, and so is the command byte that follows. `alert_pull` drops once that command byte has been received.
- R7: A read (R/W bit 1) to `own_addr` is acknowledged whether or not the alert is asserted.
- R8: An address byte naming any other device is not acknowledged and leaves `alert_pull` unchanged.
- R9: While sending a 1 bit of its address byte, the block may see SDA low at the SCL rising edge. It then stops driving for the rest of the byte, and `alert_pull` stays asserted after the STOP.
- R10: With `timeout_cycles`=T, where T is non-zero, an alert that is not serviced stays asserted for exactly T clocks and then drops. T=0 disables the timeout.
- R11: After every STOP, `sda_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SMBus clock line |
| sda_in | input | 1 | Sampled SMBus data line |
| ev_lan_pkt | input | 1 | Pulse: network packet waiting for the controller |
| ev_status_req | input | 1 | Pulse: status request received |
| ev_status_chg | input | 1 | Pulse: status has changed |
| chg_notify_en | input | 1 | Enables alerting on status changes |
| alert_mode | input | 1 | 1 selects the alert-line notification method |
| own_addr | input | 7 | Configured 7-bit slave address |
| timeout_cycles | input | TMO_W | Alert timeout in clocks, 0 disables |
| sda_pull | output | 1 | Enable for pulling SDA low |
| alert_pull | output | 1 | Enable for pulling the alert line low |

## Verification
A clocked master model in the bench runs several kinds of transfer, and a behavioural model of the alert line is compared on every clock:

- Alert response cycles with and without a pending alert separate acknowledgement from silence.
- An alert response cycle where a competing device sends a lower address separates winning and releasing from losing and keeping the alert.
- Writes and reads to the own address show that a command byte releases the alert and an address byte alone does not.
- Writes to a foreign address show they are ignored.
- Each event input is tried with the mode and change-enable inputs both set and cleared.
- A timed run places the timeout release within a few clocks of the programmed count.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ARA,
        ST_TX,
        ST_TX_ACK,
        ST_ACK_WR,
        ST_RX_CMD,
        ST_ACK_CMD,
        ST_ACK_RD,
        ST_WAIT_STOP
    } smb_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alert_mode,
    input  logic             ev_lan_pkt,
    input  logic             ev_status_req,
    input  logic             ev_status_chg,
    input  logic             chg_notify_en,
    input  logic             svc_release,
    input  logic [TMO_W-1:0] timeout_cycles,
    output logic             pending
);
    logic             trig, tmo_hit;
    logic [TMO_W-1:0] age;

    assign trig    = alert_mode & (ev_lan_pkt | ev_status_req |
                                   (ev_status_chg & chg_notify_en));
    assign tmo_hit = pending && (timeout_cycles != '0) &&
                     (age == timeout_cycles - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            age     <= '0;
        end else begin
            if (trig)
                pending <= 1'b1;
            else if (svc_release || tmo_hit)
                pending <= 1'b0;

            if (!pending || tmo_hit)
                age <= '0;
            else
                age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/smb_alert_fsm.sv
module smb_alert_fsm
    import smb_alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [6:0] own_addr,
    input  logic       alerting,
    output logic       sda_pull,
    output logic       svc_release
);
    smb_state_t state, nxt_state;
    logic [3:0] bit_cnt, nxt_bit_cnt;
    logic [7:0] shreg, nxt_shreg;
    logic [7:0] tx, nxt_tx;
    logic       drive, nxt_drive;
    logic       ara_won, nxt_ara_won;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            drive   <= 1'b0;
            ara_won <= 1'b0;
        end else begin
            state   <= nxt_state;
            bit_cnt <= nxt_bit_cnt;
            shreg   <= nxt_shreg;
            tx      <= nxt_tx;
            drive   <= nxt_drive;
            ara_won <= nxt_ara_won;
        end
    end

    // next state and outputs
    always_comb begin
        nxt_state   = state;
        nxt_bit_cnt = bit_cnt;
        nxt_shreg   = shreg;
        nxt_tx      = tx;
        nxt_drive   = drive;
        nxt_ara_won = ara_won;
        svc_release = 1'b0;
        if (stop_det || start_det) begin
            svc_release = ara_won;
            nxt_ara_won = 1'b0;
            nxt_drive   = 1'b0;
            nxt_bit_cnt = '0;
            nxt_state   = stop_det ? ST_IDLE : ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT_STOP: ;
                ST_ADDR, ST_RX_CMD: begin
                    if (scl_rise) begin
                        nxt_shreg   = {shreg[6:0], sda_s};
                        nxt_bit_cnt = bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        nxt_bit_cnt = '0;
                        if (state == ST_RX_CMD) begin
                            nxt_state   = ST_ACK_CMD;
                            nxt_drive   = 1'b1;
                            svc_release = 1'b1;
                        end else if (shreg[7:1] == ARA_ADDR && shreg[0] && alerting) begin
                            nxt_state = ST_ACK_ARA;
                            nxt_drive = 1'b1;
                            nxt_tx    = {own_addr, 1'b1};
                        end else if (shreg[7:1] == own_addr) begin
                            nxt_state = shreg[0] ? ST_ACK_RD : ST_ACK_WR;
                            nxt_drive = 1'b1;
                        end else begin
                            nxt_state = ST_WAIT_STOP;
                        end
                    end
                end
                ST_ACK_ARA: if (scl_fall) begin
                    nxt_state = ST_TX;
                    nxt_drive = ~tx[7];
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (tx[7] && !sda_s) begin
                            nxt_state = ST_WAIT_STOP;
                            nxt_drive = 1'b0;
                        end else begin
                            nxt_tx      = {tx[6:0], 1'b0};
                            nxt_bit_cnt = bit_cnt + 4'd1;
                        end
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            nxt_state = ST_TX_ACK;
                            nxt_drive = 1'b0;
                        end else begin
                            nxt_drive = ~tx[7];
                        end
                    end
                end
                ST_TX_ACK: if (scl_rise) begin
                    nxt_ara_won = 1'b1;
                    nxt_state   = ST_WAIT_STOP;
                end
                ST_ACK_WR: if (scl_fall) begin
                    nxt_state   = ST_RX_CMD;
                    nxt_drive   = 1'b0;
                    nxt_bit_cnt = '0;
                end
                ST_ACK_CMD, ST_ACK_RD: if (scl_fall) begin
                    nxt_state = ST_WAIT_STOP;
                    nxt_drive = 1'b0;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    assign sda_pull = drive;
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             ev_lan_pkt,
    input  logic             ev_status_req,
    input  logic             ev_status_chg,
    input  logic             chg_notify_en,
    input  logic             alert_mode,
    input  logic [6:0]       own_addr,
    input  logic [TMO_W-1:0] timeout_cycles,
    output logic             sda_pull,
    output logic             alert_pull
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, svc_release;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_alert_ctrl #(.TMO_W(TMO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .alert_mode(alert_mode),
        .ev_lan_pkt(ev_lan_pkt), .ev_status_req(ev_status_req),
        .ev_status_chg(ev_status_chg), .chg_notify_en(chg_notify_en),
        .svc_release(svc_release), .timeout_cycles(timeout_cycles),
        .pending(alert_pull)
    );

    smb_alert_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .alerting(alert_pull), .sda_pull(sda_pull),
        .svc_release(svc_release)
    );
endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk #(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input logic             svc_release,
    input logic             alert_mode,
    input logic             ev_lan_pkt,
    input logic             ev_status_req,
    input logic             ev_status_chg,
    input logic             chg_notify_en,
    input logic [TMO_W-1:0] timeout_cycles,
    input logic             sda_pull,
    input logic             alert_pull
);
    AST_ALERT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_pull) |-> $past(alert_mode && (ev_lan_pkt || ev_status_req ||
                                    (ev_status_chg && chg_notify_en)))); // R2

    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s); // R3

    AST_ALERT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_pull) |-> ($past(svc_release) || $past(timeout_cycles != '0))); // R4

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull); // R11
endmodule

bind smb_alert_responder smb_alert_chk #(.TMO_W(TMO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .svc_release(svc_release), .alert_mode(alert_mode), .ev_lan_pkt(ev_lan_pkt),
    .ev_status_req(ev_status_req), .ev_status_chg(ev_status_chg),
    .chg_notify_en(chg_notify_en), .timeout_cycles(timeout_cycles),
    .sda_pull(sda_pull), .alert_pull(alert_pull)
);

// File: tb/smb_alert_responder_tb.sv
`timescale 1ns/1ps
module smb_alert_responder_tb;
    localparam int TMO_W = 16;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic ev_lan = 1'b0, ev_req = 1'b0, ev_chg = 1'b0;
    logic chg_en = 1'b0, amode = 1'b1;
    logic [TMO_W-1:0] tmo = '0;
    logic sda_pull, alert_pull;
    wire  bus_sda = m_sda & ~sda_pull;

    int vectors = 0, miscompares = 0, cyc = 0, settle_until = 0;
    logic exp_alert = 1'b0;
    logic mon_on = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    smb_alert_responder #(.TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda),
        .ev_lan_pkt(ev_lan), .ev_status_req(ev_req), .ev_status_chg(ev_chg),
        .chg_notify_en(chg_en), .alert_mode(amode), .own_addr(OWN),
        .timeout_cycles(tmo), .sda_pull(sda_pull), .alert_pull(alert_pull)
    );

    // per-clock comparison of the alert line with the bench model
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_on && cyc >= settle_until) begin
            vectors++;
            if (alert_pull !== exp_alert) begin
                miscompares++;
                $display("FAIL R2/R4/R6/R10 alert model cyc %0d: actual %b expected %b",
                         cyc, alert_pull, exp_alert);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_alert(input logic v, input int slack);
        exp_alert    = v;
        settle_until = cyc + slack;
    endtask

    task automatic half();  repeat (8) @(negedge clk); endtask
    task automatic quart(); repeat (2) @(negedge clk); endtask

    task automatic do_start();
        m_sda = 1'b1; m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; quart();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic xfer_bit(input logic b, output logic v);
        m_sda = b; half();
        m_scl = 1'b1; half();
        v = bus_sda;
        m_scl = 1'b0; quart();
    endtask

    task automatic xfer_byte(input logic [7:0] mb, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic v;
            xfer_bit(mb[i], v);
            got[i] = v;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_lan = 1'b1;
            1: ev_req = 1'b1;
            default: ev_chg = 1'b1;
        endcase
        @(negedge clk);
        ev_lan = 1'b0; ev_req = 1'b0; ev_chg = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        logic ack;
        repeat (3) @(negedge clk);
        check(sda_pull, 1'b0, "R1 sda_pull in reset");
        check(alert_pull, 1'b0, "R1 alert_pull in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sda_pull, 1'b0, "R1 sda_pull after reset");
        mon_on = 1'b1;

        // R2: packet event, then R3/R4 alert response cycle
        pulse(0); model_alert(1'b1, cyc + 2 - cyc);
        repeat (3) @(negedge clk);
        check(alert_pull, 1'b1, "R2 lan event raises alert");
        do_start();
        xfer_byte(8'h19, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b0, "R3 ARA acknowledged");
        xfer_byte(8'hFF, got);
        vectors++;
        if (got !== {OWN, 1'b1}) begin
            miscompares++;
            $display("FAIL R3 ARA data: actual %h expected %h", got, {OWN, 1'b1});
        end
        xfer_bit(1'b1, ack);
        check(alert_pull, 1'b1, "R4 alert held until STOP");
        m_sda = 1'b0; half(); m_scl = 1'b1; half();
        m_sda = 1'b1; model_alert(1'b0, 8); half();
        check(alert_pull, 1'b0, "R4 alert dropped after ARA");
        check(sda_pull, 1'b0, "R11 bus released after STOP");

        // R5: ARA with no alert pending
        do_start();
        xfer_byte(8'h19, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b1, "R5 ARA not acknowledged when idle");
        xfer_byte(8'hFF, got);
        check(got == 8'hFF, 1'b1, "R5 SDA not pulled when idle");
        do_stop();

        // R2: change event gated by enable
        pulse(2); repeat (3) @(negedge clk);
        check(alert_pull, 1'b0, "R2 change ignored when disabled");
        chg_en = 1'b1;
        pulse(2); model_alert(1'b1, cyc + 2 - cyc);
        repeat (3) @(negedge clk);
        check(alert_pull, 1'b1, "R2 change raises alert when enabled");

        // R8: foreign address leaves alert alone
        do_start();
        xfer_byte(8'hA0, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b1, "R8 foreign address not acknowledged");
        xfer_byte(8'h02, got);
        do_stop();
        check(alert_pull, 1'b1, "R8 alert unchanged by foreign access");

        // R6: direct write with command byte releases alert
        do_start();
        xfer_byte({OWN, 1'b0}, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b0, "R6 own write address acknowledged");
        check(alert_pull, 1'b1, "R6 alert kept after address only");
        xfer_byte(8'h02, got);
        model_alert(1'b0, 8);
        xfer_bit(1'b1, ack);
        check(ack, 1'b0, "R6 command byte acknowledged");
        check(alert_pull, 1'b0, "R6 alert dropped after command byte");
        do_stop();

        // R2: mode off blocks events; R7: read acked while not alerting
        amode = 1'b0;
        pulse(1); repeat (3) @(negedge clk);
        check(alert_pull, 1'b0, "R2 request ignored with mode off");
        amode = 1'b1;
        do_start();
        xfer_byte({OWN, 1'b1}, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b0, "R7 own read acknowledged without alert");
        do_stop();

        // R9: lose arbitration to a lower address
        pulse(1); model_alert(1'b1, cyc + 2 - cyc);
        repeat (3) @(negedge clk);
        check(alert_pull, 1'b1, "R2 request raises alert");
        do_start();
        xfer_byte(8'h19, got);
        xfer_bit(1'b1, ack);
        check(ack, 1'b0, "R9 ARA acknowledged");
        xfer_byte({7'h51, 1'b1}, got);
        vectors++;
        if (got !== {7'h51, 1'b1}) begin
            miscompares++;
            $display("FAIL R9 arbitration byte: actual %h expected %h", got, {7'h51, 1'b1});
        end
        xfer_bit(1'b1, ack);
        do_stop();
        check(alert_pull, 1'b1, "R9 alert kept after lost arbitration");

        // clear it, then R10 timeout
        do_start();
        xfer_byte({OWN, 1'b0}, got);
        xfer_bit(1'b1, ack);
        xfer_byte(8'h02, got);
        model_alert(1'b0, 8);
        xfer_bit(1'b1, ack);
        do_stop();
        repeat (10) @(negedge clk);
        tmo = 16'd50;
        pulse(0); model_alert(1'b1, 2);
        repeat (44) @(negedge clk);
        check(alert_pull, 1'b1, "R10 alert before timeout");
        model_alert(1'b0, 6);
        repeat (8) @(negedge clk);
        check(alert_pull, 1'b0, "R10 alert after timeout");
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule